// File: doc/BRIEF.md
# Serial GPIO Input Interrupt Controller

This block turns the input bits collected by a serial GPIO shift engine into interrupts. The engine delivers one snapshot of all inputs together with an update strobe. The inputs are arranged as NBIT bit indexes, each holding NPORT ports. The block keeps the last snapshot it accepted and compares each new one against it. Depending on a per-pin trigger type, it either records a selected edge in a sticky status bit or reports the live level of the pin.

Software-side configuration arrives on a simple write port. A kind code selects the register class, an index selects the bit index, and a data word carries one bit per port. The pending sources that are also enabled are reported per bit index as a port bitmask on the `ident` vector. A single `irq` line raises when any of them is set and the master enable is on. Address decoding and the serial shift engine sit outside this block.

Top module: `sgio_irq_unit`

## Requirements
- R1: After synchronous reset, all enables, trigger types, polarities, held samples, sticky edge bits and the master enable are zero, so `ident` and `irq` are 0.
- R2: A write with `cfg_we`=1 takes effect at that clock edge. `cfg_kind` selects the target: 0 enable, 1 trigger type, 2 polarity, 3 acknowledge, 4 master. For kinds 0, 2 and 3, `cfg_idx` must be below NBIT or the write is ignored. For kind 1, index b (b < NBIT) writes trigger-type bit 0 of bit index b, and index NBIT+b writes trigger-type bit 1. Any other index is ignored. In every write, data bit p addresses port p.
- R3: The trigger type of a pin is {high bit, low bit}. Value 0 is level, 1 is both edges, 2 is falling edge and 3 is rising edge. On each `smp_valid` cycle the new sample is compared with the held sample, whose reset value is 0, and the held sample is then replaced.
- R4: A pin of type 0 is pending whenever its held sample equals its active level. Polarity 0 means active high and polarity 1 means active low. This status is not latched.
- R5: A pin of an edge type becomes pending at the strobe that carries its selected edge, and it stays pending until it is acknowledged. An acknowledge write clears the sticky bit of each port whose data bit is 1. Data bits that are 0 have no effect.
- R6: If an acknowledge and a new selected edge for the same pin fall in the same cycle, the pin stays pending.
- R7: An acknowledge has no effect on a level-type pin while its active level persists.
- R8: `ident[b*NPORT+p]` equals pin (b,p) pending AND its enable bit.
- R9: `irq` is 1 exactly when the master enable (data bit 0 of a kind-4 write) is 1 and any `ident` bit is 1.
- R10: `smp_data` is ignored in cycles where `smp_valid` is 0.
- R11: While a pin is of type 0, its sticky edge bit is cleared. A later return to an edge type therefore does not revive an earlier edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 3 | Register class of the write |
| cfg_idx | input | $clog2(2*NBIT) | Bit index (or NBIT+b for trigger high bits) |
| cfg_wdata | input | NPORT | One data bit per port |
| smp_valid | input | 1 | Update strobe for a new input snapshot |
| smp_data | input | NBIT*NPORT | Snapshot, bit index b in slice b |
| ident | output | NBIT*NPORT | Pending and enabled sources, slice b per bit index |
| irq | output | 1 | Combined interrupt |

## Verification
Every configuration write and every accepted strobe is captured at one rising edge. `ident` and `irq` are decoded from registers only, so each effect is due exactly one edge after the stimulus, with no further latency. The bench drives inputs at a falling edge and compares both outputs at the next falling edge against its own arithmetic model. Sweeps over all trigger-type and polarity mixes, combined with changing snapshots, cover each pin of a small 2-by-4 configuration.

// File: rtl/sgio_irq_pkg.sv
package sgio_irq_pkg;

    typedef enum logic [2:0] {
        CFG_ENABLE   = 3'd0,
        CFG_TRIGGER  = 3'd1,
        CFG_POLARITY = 3'd2,
        CFG_ACK      = 3'd3,
        CFG_MASTER   = 3'd4
    } cfg_kind_e;

    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_BOTH  = 2'd1,
        TRIG_FALL  = 2'd2,
        TRIG_RISE  = 2'd3
    } trig_e;

    // True when the transition from 'was' to 'now' matches trigger type t.
    function automatic logic edge_seen(trig_e t, logic was, logic now);
        case (t)
            TRIG_BOTH: return was ^ now;
            TRIG_FALL: return was & ~now;
            TRIG_RISE: return ~was & now;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sgio_irq_cfg.sv
module sgio_irq_cfg
    import sgio_irq_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NBIT  = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             we,
    input  logic [2:0]                       kind,
    input  logic [$clog2(2*NBIT)-1:0]        idx,
    input  logic [NPORT-1:0]                 wdata,
    output logic [NBIT-1:0][NPORT-1:0]       en_q,
    output logic [NBIT-1:0][NPORT-1:0]       tlo_q,
    output logic [NBIT-1:0][NPORT-1:0]       thi_q,
    output logic [NBIT-1:0][NPORT-1:0]       pol_q,
    output logic [NBIT-1:0][NPORT-1:0]       ack,
    output logic                             master_q
);
    localparam int IW = $clog2(2*NBIT);

    cfg_kind_e k;
    assign k = cfg_kind_e'(kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= '0;
            tlo_q    <= '0;
            thi_q    <= '0;
            pol_q    <= '0;
            master_q <= 1'b0;
        end else if (we) begin
            for (int b = 0; b < NBIT; b++) begin
                if (idx == IW'(b)) begin
                    if (k == CFG_ENABLE)   en_q[b]  <= wdata;
                    if (k == CFG_TRIGGER)  tlo_q[b] <= wdata;
                    if (k == CFG_POLARITY) pol_q[b] <= wdata;
                end
                if (idx == IW'(NBIT + b) && k == CFG_TRIGGER)
                    thi_q[b] <= wdata;
            end
            if (k == CFG_MASTER) master_q <= wdata[0];
        end
    end

    // Write-one-to-clear pulses, applied at the same edge as the write.
    always_comb begin
        for (int b = 0; b < NBIT; b++) begin
            ack[b] = (we && k == CFG_ACK && idx == IW'(b)) ? wdata : '0;
        end
    end

endmodule

// File: rtl/sgio_irq_lane.sv
module sgio_irq_lane
    import sgio_irq_pkg::*;
#(
    parameter int NPORT = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [NPORT-1:0] sample,
    input  logic [NPORT-1:0] tlo,
    input  logic [NPORT-1:0] thi,
    input  logic [NPORT-1:0] pol,
    input  logic [NPORT-1:0] ack,
    output logic [NPORT-1:0] pending
);
    logic [NPORT-1:0] held_q;
    logic [NPORT-1:0] sticky_q;
    logic [NPORT-1:0] hit;
    logic [NPORT-1:0] edge_mode;
    logic [NPORT-1:0] level_on;

    always_comb begin
        trig_e t;
        for (int p = 0; p < NPORT; p++) begin
            t            = trig_e'({thi[p], tlo[p]});
            edge_mode[p] = (t != TRIG_LEVEL);
            hit[p]       = strobe && edge_seen(t, held_q[p], sample[p]);
            level_on[p]  = held_q[p] ^ pol[p];
            pending[p]   = edge_mode[p] ? sticky_q[p] : level_on[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q   <= '0;
            sticky_q <= '0;
        end else begin
            // A same-cycle edge wins over the acknowledge.
            sticky_q <= ((sticky_q & ~ack) | hit) & edge_mode;
            if (strobe) held_q <= sample;
        end
    end

endmodule

// File: rtl/sgio_irq_merge.sv
module sgio_irq_merge #(
    parameter int NPORT = 32,
    parameter int NBIT  = 4
) (
    input  logic [NBIT-1:0][NPORT-1:0] pend,
    input  logic [NBIT-1:0][NPORT-1:0] en,
    input  logic                       master,
    output logic [NBIT*NPORT-1:0]      ident,
    output logic                       irq
);
    assign ident = pend & en;
    assign irq   = master & (|ident);
endmodule

// File: rtl/sgio_irq_unit.sv
module sgio_irq_unit
    import sgio_irq_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NBIT  = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_we,
    input  logic [2:0]                    cfg_kind,
    input  logic [$clog2(2*NBIT)-1:0]     cfg_idx,
    input  logic [NPORT-1:0]              cfg_wdata,
    input  logic                          smp_valid,
    input  logic [NBIT*NPORT-1:0]         smp_data,
    output logic [NBIT*NPORT-1:0]         ident,
    output logic                          irq
);
    logic [NBIT-1:0][NPORT-1:0] en_q, tlo_q, thi_q, pol_q, ack, pend;
    logic                       master_q;

    sgio_irq_cfg #(.NPORT(NPORT), .NBIT(NBIT)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .kind     (cfg_kind),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .en_q     (en_q),
        .tlo_q    (tlo_q),
        .thi_q    (thi_q),
        .pol_q    (pol_q),
        .ack      (ack),
        .master_q (master_q)
    );

    for (genvar b = 0; b < NBIT; b++) begin : g_lane
        sgio_irq_lane #(.NPORT(NPORT)) u_lane (
            .clk     (clk),
            .rst     (rst),
            .strobe  (smp_valid),
            .sample  (smp_data[b*NPORT +: NPORT]),
            .tlo     (tlo_q[b]),
            .thi     (thi_q[b]),
            .pol     (pol_q[b]),
            .ack     (ack[b]),
            .pending (pend[b])
        );
    end

    sgio_irq_merge #(.NPORT(NPORT), .NBIT(NBIT)) u_merge (
        .pend   (pend),
        .en     (en_q),
        .master (master_q),
        .ident  (ident),
        .irq    (irq)
    );

endmodule

// File: rtl/sgio_irq_unit_chk.sv
module sgio_irq_unit_chk
    import sgio_irq_pkg::*;
#(
    parameter int NPORT = 32,
    parameter int NBIT  = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      cfg_we,
    input logic [2:0]                cfg_kind,
    input logic [$clog2(2*NBIT)-1:0] cfg_idx,
    input logic [NPORT-1:0]          cfg_wdata,
    input logic                      smp_valid,
    input logic [NBIT*NPORT-1:0]     ident,
    input logic                      irq
);
    localparam int IW = $clog2(2*NBIT);

    logic [IW-1:0]    idx_q;
    logic [NPORT-1:0] lane_at_idx;

    always_ff @(posedge clk) idx_q <= cfg_idx;

    always_comb begin
        lane_at_idx = '0;
        for (int b = 0; b < NBIT; b++)
            if (idx_q == IW'(b)) lane_at_idx = ident[b*NPORT +: NPORT];
    end

    // R9: the combined line never raises without an identified source
    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|ident));

    // R9: clearing the master enable silences the line at the next edge
    assert_master_off_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_kind == CFG_MASTER && !cfg_wdata[0]) |=> !irq);

    // R10: with no strobe and no write, nothing the outputs show can move
    assert_quiet_stable_R10: assert property (@(posedge clk) disable iff (rst)
        (!cfg_we && !smp_valid) |=> ($stable(ident) && $stable(irq)));

    // R8: zeroing a bit index's enables empties its ident slice
    assert_enable_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_kind == CFG_ENABLE && cfg_wdata == '0 && cfg_idx < IW'(NBIT))
        |=> (lane_at_idx == '0));

endmodule

bind sgio_irq_unit sgio_irq_unit_chk #(.NPORT(NPORT), .NBIT(NBIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_kind  (cfg_kind),
    .cfg_idx   (cfg_idx),
    .cfg_wdata (cfg_wdata),
    .smp_valid (smp_valid),
    .ident     (ident),
    .irq       (irq)
);

// File: tb/tb_sgio_irq_unit.sv
`timescale 1ns/1ps
module tb_sgio_irq_unit;
    localparam int NP = 4;
    localparam int NB = 2;
    localparam int IW = $clog2(2*NB);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cfg_we = 1'b0;
    logic [2:0]      cfg_kind = '0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [NP-1:0]   cfg_wdata = '0;
    logic            smp_valid = 1'b0;
    logic [NB*NP-1:0] smp_data = '0;
    logic [NB*NP-1:0] ident;
    logic            irq;

    int checks = 0;
    int errors = 0;

    // Bench model of the requirements
    logic [NP-1:0] m_en [NB];
    logic [NP-1:0] m_tl [NB];
    logic [NP-1:0] m_th [NB];
    logic [NP-1:0] m_pol[NB];
    logic [NP-1:0] m_prev[NB];
    logic [NP-1:0] m_pe [NB];
    logic          m_master;

    sgio_irq_unit #(.NPORT(NP), .NBIT(NB)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .smp_valid(smp_valid),
        .smp_data(smp_data), .ident(ident), .irq(irq)
    );

    always #2 clk = ~clk;

    function automatic logic [NB*NP-1:0] exp_ident();
        logic [NB*NP-1:0] r = '0;
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++) begin
                int t = 2*m_th[b][p] + m_tl[b][p];
                logic pend = (t == 0) ? (m_prev[b][p] ^ m_pol[b][p]) : m_pe[b][p];
                r[b*NP+p] = pend & m_en[b][p];
            end
        return r;
    endfunction

    function automatic logic edge_m(int t, logic was, logic now);
        if (t == 1) return was != now;
        if (t == 2) return was && !now;
        if (t == 3) return !was && now;
        return 1'b0;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int b = 0; b < NB; b++) begin
            m_en[b] = '0; m_tl[b] = '0; m_th[b] = '0; m_pol[b] = '0;
            m_prev[b] = '0; m_pe[b] = '0;
        end
        m_master = 1'b0;
    endtask

    // One cycle of stimulus, called at a falling edge; checks at the next one.
    task automatic op(input logic we, input int kind, input int idx,
                      input logic [NP-1:0] data, input logic sv,
                      input logic [NB*NP-1:0] sd, input string tag);
        logic [NB*NP-1:0] e;
        cfg_we = we; cfg_kind = 3'(kind); cfg_idx = IW'(idx); cfg_wdata = data;
        smp_valid = sv; smp_data = sd;
        for (int b = 0; b < NB; b++) begin
            logic [NP-1:0] ackm = (we && kind == 3 && idx == b) ? data : '0;
            for (int p = 0; p < NP; p++) begin
                int t = 2*m_th[b][p] + m_tl[b][p];
                logic hit = sv && edge_m(t, m_prev[b][p], sd[b*NP+p]);
                m_pe[b][p] = ((m_pe[b][p] & !ackm[p]) | hit) & (t != 0);
            end
        end
        if (we) begin
            if (kind == 0 && idx < NB) m_en[idx] = data;
            if (kind == 1 && idx < NB) m_tl[idx] = data;
            if (kind == 1 && idx >= NB && idx < 2*NB) m_th[idx-NB] = data;
            if (kind == 2 && idx < NB) m_pol[idx] = data;
            if (kind == 4) m_master = data[0];
        end
        if (sv) for (int b = 0; b < NB; b++) m_prev[b] = sd[b*NP +: NP];
        @(negedge clk);
        cfg_we = 1'b0; smp_valid = 1'b0;
        e = exp_ident();
        chk({tag, " ident"}, 32'(ident), 32'(e));
        chk({tag, " irq"}, 32'(irq), 32'(m_master & (|e)));
    endtask

    task automatic wr(int kind, int idx, logic [NP-1:0] data, string tag);
        op(1'b1, kind, idx, data, 1'b0, smp_data, tag);
    endtask

    task automatic strobe(logic [NB*NP-1:0] sd, string tag);
        op(1'b0, 0, 0, '0, 1'b1, sd, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 ident", 32'(ident), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2: out-of-range enable/polarity indexes are ignored
        wr(4, 0, 4'h1, "R2 master");
        strobe(8'hFF, "R4 level high");
        wr(0, 2, 4'hF, "R2 enable idx out of range");
        wr(0, 3, 4'hF, "R2 enable idx out of range");
        wr(0, 0, 4'hF, "R8 enable lane0");
        wr(2, 3, 4'hF, "R2 polarity idx out of range");
        wr(0, 1, 4'hA, "R8 enable lane1");

        // R3 R4 R5 R8 R9: sweep trigger/polarity mixes with changing samples
        for (int k = 0; k < 16; k++) begin
            wr(1, 0, 4'(k), "R3 trig lo0");
            wr(1, 1, 4'(k*7), "R3 trig lo1");
            wr(1, 2, 4'(k*5+3), "R3 trig hi0");
            wr(1, 3, 4'(k*3), "R3 trig hi1");
            wr(2, 0, 4'(k*3), "R4 pol0");
            wr(2, 1, 4'(k*11), "R4 pol1");
            wr(0, 0, 4'(k*13+9), "R8 en0");
            wr(0, 1, 4'hF, "R8 en1");
            for (int s = 0; s < 48; s++) begin
                logic [NB*NP-1:0] sd = 8'((s*37 + k*11) & 8'hFF);
                if (s % 3 == 2)
                    op(1'b1, 3, s % 2, 4'(s*5), 1'b1, sd, "R5 ack with strobe");
                else if (s % 5 == 4)
                    wr(3, s % 2, 4'hF, "R5 ack");
                else
                    strobe(sd, "R3 sweep");
            end
        end

        // R6: acknowledge and rising edge in the same cycle
        wr(1, 0, 4'hF, "R6 setup"); wr(1, 2, 4'hF, "R6 setup");
        wr(0, 0, 4'hF, "R6 setup");
        strobe(8'h00, "R6 low");
        wr(3, 0, 4'hF, "R6 clear");
        op(1'b1, 3, 0, 4'hF, 1'b1, 8'h0F, "R6 ack+edge keeps pending");
        chk("R6 lane0 pending", 32'(ident[3:0]), 32'hF);

        // R11: edge status dropped in level mode, not revived
        wr(2, 0, 4'hF, "R11 pol low");
        wr(1, 0, 4'h0, "R11 level"); wr(1, 2, 4'h0, "R11 level");
        chk("R11 inactive level", 32'(ident[3:0]), 32'h0);
        wr(1, 0, 4'hF, "R11 back to edge"); wr(1, 2, 4'hF, "R11 back to edge");
        chk("R11 no revival", 32'(ident[3:0]), 32'h0);

        // R7: ack has no effect on an active level
        wr(1, 0, 4'h0, "R7 level"); wr(1, 2, 4'h0, "R7 level");
        wr(2, 0, 4'h0, "R7 pol high");
        wr(3, 0, 4'hF, "R7 ack level");
        chk("R7 level persists", 32'(ident[3:0]), 32'hF);

        // R10: sample change without strobe is ignored
        op(1'b0, 0, 0, '0, 1'b0, 8'h00, "R10 no strobe");
        chk("R10 lane0 unchanged", 32'(ident[3:0]), 32'hF);

        // R9: master off gates the line
        wr(4, 0, 4'hE, "R9 master off via bit0");
        chk("R9 irq gated", 32'(irq), 32'h0);
        wr(4, 0, 4'h1, "R9 master on");
        chk("R9 irq raised", 32'(irq), 32'h1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule